// File: doc/BRIEF.md
# Vectored Interrupt Queue Controller

This block sits beside an instruction sequencer and owns everything about interrupt entry. Devices post 16-bit messages on a push port. They are held in a circular buffer until the sequencer raises its instruction-boundary strobe. At that point the block decides whether to dequeue a message and enter the handler. An entry stores the return address and the accumulator on the stack through a one-word-per-cycle memory port. It then hands the sequencer new values for the program counter, stack pointer and accumulator.

The sequencer forwards five execute-stage commands to the block:
- a software interrupt that skips the buffer;
- writing the vector address;
- reading the vector address;
- the return-from-handler command, which restores the accumulator and program counter from the stack;
- a control that turns dequeuing on or off.

While a multi-cycle sequence runs, `busy` stalls the sequencer. If the buffer is full at a boundary, a fault flag is set and stays set until reset.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset the buffer is empty, the vector address is 0, dequeuing is enabled, and `fault`, `busy`, `upd_valid`, `rd_valid`, `mem_we` and `mem_re` are all 0.
- R2: A message on `irq_valid` is stored only if the vector address is non-zero and fewer than 256 messages are held. Otherwise it is dropped silently.
- R3: At a boundary taken while idle, with dequeuing enabled and at least one message held, the oldest message is removed. If the vector address is 0 at that moment, the message is discarded and nothing else happens.
- R4: Entering a handler on a dequeued message takes these steps:
  - Dequeuing is disabled.
  - In the next cycle, `pc_in` is written at `sp_in-1`.
  - In the cycle after that, `a_in` is written at `sp_in-2`, together with an update pulse carrying PC = vector address, SP = `sp_in-2` and A = the message.
  - `busy` is high during those two cycles.
- R5: A boundary taken while 256 messages are held sets `fault`, which then stays 1 until reset.
- R6: Software interrupt (`cmd`=1) occupies 4 cycles, with `busy` high in the last 3. With a non-zero vector address, it disables dequeuing, then:
  - writes `pc_in` (the return address) at `sp_in-1`;
  - writes `a_in` at `sp_in-2`;
  - pulses an update with PC = vector address, SP = `sp_in-2` and A = `a_in`.

  With a zero vector address, it makes no writes and no update. It never touches the buffer.
- R7: Return (`cmd`=4) enables dequeuing and occupies 3 cycles. In the first busy cycle it reads A from `sp_in`. In the second it reads PC from `sp_in+1` and pulses an update with SP = `sp_in+2`. Memory reads are combinational: `mem_rdata` answers `mem_addr` in the same cycle.
- R8: Queue control (`cmd`=5) enables dequeuing when `cmd_arg` is 0 and disables it otherwise. It occupies 2 cycles, with `busy` high in the second.
- R9: Set-vector (`cmd`=2) loads `cmd_arg` into the vector address in one cycle without `busy`. Get-vector (`cmd`=3) returns the vector address on `rd_data` with `rd_valid` high in the following cycle.
- R10: A push and a boundary removal in the same cycle leave the held count unchanged, and messages leave in arrival order.
- R11: A boundary takes priority over a command in the same cycle, which is then ignored. Boundaries and commands that arrive while `busy` is high are ignored. The code `cmd`=0 means no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid | input | 1 | Device message offered this cycle |
| irq_msg | input | 16 | Device message |
| boundary | input | 1 | Instruction-boundary strobe |
| cmd | input | 3 | Command code (0 none, 1 soft interrupt, 2 set vector, 3 get vector, 4 return, 5 queue control) |
| cmd_arg | input | 16 | Command operand |
| pc_in | input | 16 | Current return address from the sequencer |
| sp_in | input | 16 | Current stack pointer |
| a_in | input | 16 | Current accumulator |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 16 | Stack word address |
| mem_wdata | output | 16 | Stack write data |
| mem_rdata | input | 16 | Stack read data, same cycle |
| upd_valid | output | 1 | Register update pulse |
| pc_new | output | 16 | New program counter |
| sp_new | output | 16 | New stack pointer |
| a_new | output | 16 | New accumulator |
| rd_valid | output | 1 | Vector read result valid |
| rd_data | output | 16 | Vector address read result |
| busy | output | 1 | Sequence in progress; stall the sequencer |
| fault | output | 1 | Sticky overflow fault |

## Verification
The checker watches the following on every cycle:
- the held count never exceeds 256;
- pushes offered with a zero vector address leave the count alone;
- a simultaneous push and removal keeps the count;
- `fault` never falls;
- memory traffic appears only while `busy`;
- an update pulse ends the busy window;
- a removal happens only at an idle boundary.

Only the bench scenarios can show the rest:
- the exact write addresses and data;
- the values carried by each update;
- first-in first-out ordering;
- the discard-on-zero-vector path;
- that a command colliding with a boundary is lost.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int WORD_W = 16;
    localparam int QPTR_W = 8;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_SWINT  = 3'd1,
        CMD_SETVEC = 3'd2,
        CMD_GETVEC = 3'd3,
        CMD_RETURN = 3'd4,
        CMD_QCTRL  = 3'd5
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENT_PC,
        ST_ENT_A,
        ST_SW_RET,
        ST_SW_A,
        ST_SW_UPD,
        ST_RFI_A,
        ST_RFI_PC,
        ST_QWAIT
    } seq_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] a;
    } regupd_t;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } stackop_t;
endpackage

// File: rtl/irqv_fifo.sv
module irqv_fifo #(
    parameter int W     = 16,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [PTR_W:0]   count
);
    localparam int DEPTH = 1 << PTR_W;

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = store[rd_ptr];
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
    import irqv_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         boundary,
    input  cmd_e         cmd,
    input  logic [W-1:0] cmd_arg,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] sp_in,
    input  logic [W-1:0] a_in,
    input  logic         q_nonempty,
    input  logic         q_full,
    input  logic [W-1:0] q_head,
    input  logic [W-1:0] mem_rdata,
    output logic         q_pop,
    output logic         ia_nz,
    output logic         busy,
    output logic         fault,
    output stackop_t     mop,
    output regupd_t      upd,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    seq_e         st_q;
    logic [W-1:0] ia_q, pc_q, sp_q, a_q, msg_q;
    logic         qen_q, go_q;

    logic idle, take_bnd, take_cmd, enter;

    assign idle     = (st_q == ST_IDLE);
    assign busy     = !idle;
    assign ia_nz    = (ia_q != '0);
    assign take_bnd = boundary && idle;
    assign q_pop    = take_bnd && qen_q && q_nonempty;
    assign enter    = q_pop && ia_nz;
    assign take_cmd = idle && !boundary && (cmd != CMD_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ia_q     <= '0;
            qen_q    <= 1'b1;
            fault    <= 1'b0;
            go_q     <= 1'b0;
            pc_q     <= '0;
            sp_q     <= '0;
            a_q      <= '0;
            msg_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (take_bnd) begin
                        if (q_full) fault <= 1'b1;
                        if (enter) begin
                            qen_q <= 1'b0;
                            pc_q  <= pc_in;
                            sp_q  <= sp_in;
                            a_q   <= a_in;
                            msg_q <= q_head;
                            st_q  <= ST_ENT_PC;
                        end
                    end else if (take_cmd) begin
                        unique case (cmd)
                            CMD_SWINT: begin
                                pc_q <= pc_in;
                                sp_q <= sp_in;
                                a_q  <= a_in;
                                go_q <= ia_nz;
                                if (ia_nz) qen_q <= 1'b0;
                                st_q <= ST_SW_RET;
                            end
                            CMD_SETVEC: ia_q <= cmd_arg;
                            CMD_GETVEC: begin
                                rd_valid <= 1'b1;
                                rd_data  <= ia_q;
                            end
                            CMD_RETURN: begin
                                qen_q <= 1'b1;
                                sp_q  <= sp_in;
                                st_q  <= ST_RFI_A;
                            end
                            CMD_QCTRL: begin
                                qen_q <= (cmd_arg == '0);
                                st_q  <= ST_QWAIT;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ENT_PC: st_q <= ST_ENT_A;
                ST_ENT_A:  st_q <= ST_IDLE;
                ST_SW_RET: st_q <= ST_SW_A;
                ST_SW_A:   st_q <= ST_SW_UPD;
                ST_SW_UPD: st_q <= ST_IDLE;
                ST_RFI_A: begin
                    a_q  <= mem_rdata;
                    st_q <= ST_RFI_PC;
                end
                ST_RFI_PC: st_q <= ST_IDLE;
                ST_QWAIT:  st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mop = '0;
        upd = '0;
        unique case (st_q)
            ST_ENT_PC: mop = '{we: 1'b1, re: 1'b0, addr: sp_q - ONE, wdata: pc_q};
            ST_ENT_A: begin
                mop = '{we: 1'b1, re: 1'b0, addr: sp_q - TWO, wdata: a_q};
                upd = '{valid: 1'b1, pc: ia_q, sp: sp_q - TWO, a: msg_q};
            end
            ST_SW_RET: if (go_q) mop = '{we: 1'b1, re: 1'b0, addr: sp_q - ONE, wdata: pc_q};
            ST_SW_A:   if (go_q) mop = '{we: 1'b1, re: 1'b0, addr: sp_q - TWO, wdata: a_q};
            ST_SW_UPD: if (go_q) upd = '{valid: 1'b1, pc: ia_q, sp: sp_q - TWO, a: a_q};
            ST_RFI_A:  mop = '{we: 1'b0, re: 1'b1, addr: sp_q, wdata: '0};
            ST_RFI_PC: begin
                mop = '{we: 1'b0, re: 1'b1, addr: sp_q + ONE, wdata: '0};
                upd = '{valid: 1'b1, pc: mem_rdata, sp: sp_q + TWO, a: a_q};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int PTR_W = QPTR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         irq_valid,
    input  logic [W-1:0] irq_msg,
    input  logic         boundary,
    input  logic [2:0]   cmd,
    input  logic [W-1:0] cmd_arg,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] sp_in,
    input  logic [W-1:0] a_in,
    output logic         mem_we,
    output logic         mem_re,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         upd_valid,
    output logic [W-1:0] pc_new,
    output logic [W-1:0] sp_new,
    output logic [W-1:0] a_new,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         busy,
    output logic         fault
);
    logic [PTR_W:0] q_count;
    logic [W-1:0]   q_head;
    logic           q_push, q_pop, ia_nz, q_full;
    stackop_t       mop;
    regupd_t        upd;

    assign q_full = q_count[PTR_W];
    assign q_push = irq_valid && ia_nz && !q_full;

    irqv_fifo #(.W(W), .PTR_W(PTR_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (irq_msg),
        .pop       (q_pop),
        .head      (q_head),
        .count     (q_count)
    );

    irqv_seq #(.W(W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .boundary   (boundary),
        .cmd        (cmd_e'(cmd)),
        .cmd_arg    (cmd_arg),
        .pc_in      (pc_in),
        .sp_in      (sp_in),
        .a_in       (a_in),
        .q_nonempty (q_count != '0),
        .q_full     (q_full),
        .q_head     (q_head),
        .mem_rdata  (mem_rdata),
        .q_pop      (q_pop),
        .ia_nz      (ia_nz),
        .busy       (busy),
        .fault      (fault),
        .mop        (mop),
        .upd        (upd),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign mem_we    = mop.we;
    assign mem_re    = mop.re;
    assign mem_addr  = mop.addr;
    assign mem_wdata = mop.wdata;
    assign upd_valid = upd.valid;
    assign pc_new    = upd.pc;
    assign sp_new    = upd.sp;
    assign a_new     = upd.a;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
#(
    parameter int PTR_W = QPTR_W
) (
    input logic           clk,
    input logic           rst,
    input logic           irq_valid,
    input logic           ia_nz,
    input logic           q_push,
    input logic           q_pop,
    input logic [PTR_W:0] q_count,
    input logic           boundary,
    input logic [2:0]     cmd,
    input logic           busy,
    input logic           fault,
    input logic           mem_we,
    input logic           mem_re,
    input logic           upd_valid
);
    localparam int DEPTH = 1 << PTR_W;

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        q_count <= (PTR_W+1)'(DEPTH));

    a_r2_zero_vec_drop: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !ia_nz && !q_pop) |=> $stable(q_count));

    a_r10_push_pop_keep: assert property (@(posedge clk) disable iff (rst)
        (q_push && q_pop) |=> $stable(q_count));

    a_r5_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    a_r4_mem_in_busy: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    a_r4_upd_ends_busy: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> !busy);

    a_r11_pop_idle_only: assert property (@(posedge clk) disable iff (rst)
        q_pop |-> (boundary && !busy));

    a_r8_qctrl_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy && !boundary && cmd == CMD_QCTRL) |=> busy);
endmodule

bind irqv_ctrl irqv_checker #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_valid (irq_valid),
    .ia_nz     (ia_nz),
    .q_push    (q_push),
    .q_pop     (q_pop),
    .q_count   (q_count),
    .boundary  (boundary),
    .cmd       (cmd),
    .busy      (busy),
    .fault     (fault),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .upd_valid (upd_valid)
);

// File: tb/test_irqv_ctrl.sv
module test_irqv_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        irq_valid;
    logic [15:0] irq_msg;
    logic        boundary;
    logic [2:0]  cmd;
    logic [15:0] cmd_arg, pc_in, sp_in, a_in;
    logic        mem_we, mem_re, upd_valid, rd_valid, busy, fault;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_new, sp_new, a_new, rd_data;

    always #4 clk = ~clk;

    irqv_ctrl i_irqv_ctrl (
        .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_msg(irq_msg),
        .boundary(boundary), .cmd(cmd), .cmd_arg(cmd_arg),
        .pc_in(pc_in), .sp_in(sp_in), .a_in(a_in),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .upd_valid(upd_valid), .pc_new(pc_new), .sp_new(sp_new), .a_new(a_new),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .fault(fault)
    );

    // stack memory environment
    logic [15:0] mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";

    // reference model state
    logic [15:0] mq[$];
    logic [15:0] m_ia, m_pc, m_sp, m_a, m_msg, m_rdd;
    logic        m_qen, m_fault, m_go, m_rdv;
    int          m_kind, m_step;  // kind: 0 idle, 1 entry, 2 soft, 3 return, 4 qctrl

    task automatic model_reset();
        mq.delete();
        m_ia = 0; m_pc = 0; m_sp = 0; m_a = 0; m_msg = 0; m_rdd = 0;
        m_qen = 1; m_fault = 0; m_go = 0; m_rdv = 0; m_kind = 0; m_step = 0;
    endtask

    task automatic cmp1(string f, logic act, logic exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, f, act, exp, $time);
        end
    endtask

    task automatic cmp16(string f, logic [15:0] act, logic [15:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, f, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic e_we, e_re, e_upd;
        logic [15:0] e_addr, e_wd, e_pc, e_sp, e_a;
        e_we = 0; e_re = 0; e_upd = 0; e_addr = 0; e_wd = 0; e_pc = 0; e_sp = 0; e_a = 0;
        if (m_kind == 1) begin
            e_we = 1;
            if (m_step == 1) begin e_addr = m_sp - 16'd1; e_wd = m_pc; end
            else begin
                e_addr = m_sp - 16'd2; e_wd = m_a;
                e_upd = 1; e_pc = m_ia; e_sp = m_sp - 16'd2; e_a = m_msg;
            end
        end else if (m_kind == 2 && m_go) begin
            if (m_step == 1) begin e_we = 1; e_addr = m_sp - 16'd1; e_wd = m_pc; end
            else if (m_step == 2) begin e_we = 1; e_addr = m_sp - 16'd2; e_wd = m_a; end
            else begin e_upd = 1; e_pc = m_ia; e_sp = m_sp - 16'd2; e_a = m_a; end
        end else if (m_kind == 3) begin
            e_re = 1;
            if (m_step == 1) e_addr = m_sp;
            else begin
                e_addr = m_sp + 16'd1;
                e_upd = 1; e_pc = mem[e_addr[7:0]]; e_sp = m_sp + 16'd2; e_a = m_a;
            end
        end
        vectors++;
        cmp1("busy", busy, m_kind != 0);
        cmp1("fault", fault, m_fault);
        cmp1("mem_we", mem_we, e_we);
        cmp1("mem_re", mem_re, e_re);
        if (e_we || e_re) cmp16("mem_addr", mem_addr, e_addr);
        if (e_we) cmp16("mem_wdata", mem_wdata, e_wd);
        cmp1("upd_valid", upd_valid, e_upd);
        if (e_upd) begin
            cmp16("pc_new", pc_new, e_pc);
            cmp16("sp_new", sp_new, e_sp);
            cmp16("a_new", a_new, e_a);
        end
        cmp1("rd_valid", rd_valid, m_rdv);
        if (m_rdv) cmp16("rd_data", rd_data, m_rdd);
    endtask

    task automatic model_edge();
        int  pre;
        bit  push_ok;
        logic [15:0] old_ia;
        pre = mq.size();
        old_ia = m_ia;
        push_ok = irq_valid && (m_ia != 0) && (pre < 256);
        m_rdv = 0;
        if (m_kind != 0) begin
            int last;
            last = (m_kind == 2) ? 3 : (m_kind == 4) ? 1 : 2;
            if (m_kind == 3 && m_step == 1) m_a = mem[m_sp[7:0]];
            if (m_step == last) m_kind = 0; else m_step++;
        end else if (boundary) begin
            if (pre > 255) m_fault = 1;
            if (m_qen && pre > 0) begin
                m_msg = mq.pop_front();
                if (m_ia != 0) begin
                    m_qen = 0; m_pc = pc_in; m_sp = sp_in; m_a = a_in;
                    m_kind = 1; m_step = 1;
                end
            end
        end else if (cmd != 0) begin
            case (cmd)
                3'd1: begin
                    m_pc = pc_in; m_sp = sp_in; m_a = a_in; m_go = (m_ia != 0);
                    if (m_ia != 0) m_qen = 0;
                    m_kind = 2; m_step = 1;
                end
                3'd2: m_ia = cmd_arg;
                3'd3: begin m_rdv = 1; m_rdd = old_ia; end
                3'd4: begin m_qen = 1; m_sp = sp_in; m_kind = 3; m_step = 1; end
                3'd5: begin m_qen = (cmd_arg == 0); m_kind = 4; m_step = 1; end
                default: ;
            endcase
        end
        if (push_ok) mq.push_back(irq_msg);
    endtask

    // one cycle: inputs already set at negedge
    task automatic cyc(logic v, logic [15:0] msg, logic b, logic [2:0] c, logic [15:0] arg);
        irq_valid = v; irq_msg = msg; boundary = b; cmd = c; cmd_arg = arg;
        #1;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 16'h0, 0, 3'd0, 16'h0);
    endtask

    task automatic do_reset();
        rst = 1; irq_valid = 0; irq_msg = 0; boundary = 0; cmd = 0; cmd_arg = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 16'(k * 3);
        pc_in = 16'h0100; sp_in = 16'h0080; a_in = 16'h0005;
        do_reset();

        cur_req = "R1"; idle(3);

        cur_req = "R2";           // zero vector: drop
        cyc(1, 16'h00AA, 0, 3'd0, 0);
        cur_req = "R9";
        cyc(0, 0, 0, 3'd2, 16'h0040);
        cyc(0, 0, 0, 3'd3, 0);
        idle(1);
        cur_req = "R2"; cyc(0, 0, 1, 3'd0, 0); idle(2);   // nothing queued -> no entry

        cur_req = "R10";
        cyc(1, 16'h0011, 0, 3'd0, 0);
        cyc(1, 16'h0022, 0, 3'd0, 0);
        cyc(1, 16'h0033, 0, 3'd0, 0);
        cur_req = "R4";
        cyc(1, 16'h0044, 1, 3'd0, 0);                    // push+pop same cycle
        cur_req = "R11";
        cyc(0, 0, 1, 3'd2, 16'h0999); cyc(0, 0, 0, 3'd2, 16'h0999); // ignored while busy
        idle(1);
        cyc(0, 0, 0, 3'd3, 0); idle(1);
        cur_req = "R3"; cyc(0, 0, 1, 3'd0, 0); idle(1);  // dequeuing disabled
        cur_req = "R7";
        sp_in = 16'h007E;
        cyc(0, 0, 0, 3'd4, 0); idle(3);
        sp_in = 16'h0080;
        cur_req = "R8";
        cyc(0, 0, 0, 3'd5, 16'h0001); idle(1);
        cyc(0, 0, 1, 3'd0, 0); idle(1);
        cyc(0, 0, 0, 3'd5, 16'h0000); idle(1);
        cur_req = "R10"; cyc(0, 0, 1, 3'd0, 0); idle(3);  // pops 0x22 in order
        cur_req = "R4";
        sp_in = 16'h007E; cyc(0, 0, 0, 3'd4, 0); idle(3); sp_in = 16'h0080;
        cur_req = "R11";
        cyc(0, 0, 1, 3'd2, 16'h0000); idle(1);              // command lost to boundary
        cyc(0, 0, 0, 3'd3, 0); idle(3);
        cur_req = "R6";
        pc_in = 16'h0203; a_in = 16'h1234;
        cyc(0, 0, 0, 3'd1, 0); idle(4);
        cyc(0, 0, 0, 3'd2, 16'h0000);
        cyc(0, 0, 0, 3'd1, 0); idle(4);
        cyc(0, 0, 0, 3'd2, 16'h0040);
        cur_req = "R3";
        sp_in = 16'h0060; cyc(0, 0, 0, 3'd4, 0); idle(3); sp_in = 16'h0080;
        cyc(1, 16'h0055, 0, 3'd0, 0);
        cyc(0, 0, 0, 3'd2, 16'h0000);
        cyc(0, 0, 1, 3'd0, 0); idle(1);                  // discarded
        cyc(0, 0, 0, 3'd2, 16'h0070);
        cyc(0, 0, 1, 3'd0, 0); idle(3);

        cur_req = "R5";
        sp_in = 16'h0060; cyc(0, 0, 0, 3'd5, 16'h0007); idle(1);
        for (int k = 0; k < 260; k++) cyc(1, 16'(16'h0100 + k), 0, 3'd0, 0);
        cyc(0, 0, 1, 3'd0, 0); idle(3);
        cyc(0, 0, 0, 3'd5, 16'h0000); idle(1);
        cyc(0, 0, 1, 3'd0, 0); idle(4);
        cur_req = "R1";
        do_reset();
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule